// File: doc/BRIEF.md
# Dual Message-Buffer Interface for a Shared Message RAM

This block lets a CPU move message objects in and out of a message RAM that a CAN-style protocol engine also uses. The CPU never addresses the RAM itself. It works through one of two identical interface sets. Each set holds a five-field object buffer (arbitration, mask, control, low data word, high data word), a command register and a request register. The command register picks the direction of the next transfer and the fields it covers. Writing an object number to the request register starts a single atomic transfer of the selected fields between the buffer and that object.

A fixed-priority arbiter gives the RAM to one requester per cycle. The protocol-engine port wins over both sets, and set 0 wins over set 1. Each granted cycle moves one field. A set stays busy until its last selected field has moved, and it ignores CPU writes while it is busy. Software can dedicate one set to uploads and the other to downloads. Either set can start a transfer while the other is part-way through one, and neither transfer corrupts the other.

The protocol-engine port uses a request/grant handshake. `pe_req` acts as valid and `pe_gnt` as ready. Because the engine has top priority, `pe_gnt` follows `pe_req` in the same cycle, so the engine never sees back-pressure. A write is committed at the clock edge that ends the granted cycle. Read data is valid during the granted cycle. The CPU port uses plain write-enable and read-select pins with no handshake.

Top module: `msgif_hub`

## Requirements
- R1: Each set decodes register index 0..4 as buffer field 0..4 (arbitration, mask, control, data low, data high). Index 5 is the command register: bits [4:0] select fields and bit 7 is the direction, 1 meaning buffer to RAM. Index 6 is the request register and holds the object number in its low 4 bits. Reading index 5 returns the stored command in those bit positions, and reading index 6 returns the stored object number.
- R2: A request with direction 1 copies every selected buffer field into the chosen object and leaves the object's other fields as they were.
- R3: A request with direction 0 loads every selected field of the chosen object into the buffer and leaves the other buffer fields unchanged.
- R4: A set's busy bit rises at the clock edge that stores a valid request with a non-empty field mask. It falls at the edge that moves the last selected field, so an uncontended transfer of n fields keeps busy high for exactly n cycles.
- R5: While a set is busy, CPU writes to its buffer, command and request registers are ignored.
- R6: A request for object 0, for an object above NUM_OBJ (8), or with an empty field mask makes no RAM access, and busy stays low.
- R7: The RAM serves one access per cycle. The protocol-engine port has priority over set 0, and set 0 has priority over set 1. A set that is not granted holds its place and loses no fields.
- R8: `pe_gnt` equals `pe_req` in the same cycle. A granted write with `pe_we` high is stored at the end of that cycle. A granted read shows the addressed field on `pe_rdata` during that cycle.
- R9: Transfers on the two sets may overlap in time, and each transfer still ends with exactly the data it would have produced if it had run alone in its arbitration order.
- R10: After reset all buffers, command registers, object numbers and RAM words are zero, and both busy bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_sel | input | 1 | Interface set targeted by the write |
| cpu_reg | input | 3 | Register index of the write |
| cpu_wdata | input | 32 | Write data |
| cpu_rsel | input | 1 | Interface set for the read port |
| cpu_rreg | input | 3 | Register index for the read port |
| cpu_rdata | output | 32 | Read data (combinational) |
| busy | output | 2 | Busy bit of each set |
| pe_req | input | 1 | Protocol-engine access request (valid) |
| pe_we | input | 1 | Protocol-engine access is a write |
| pe_obj | input | 4 | Object number, 1..NUM_OBJ |
| pe_fld | input | 3 | Field index 0..4 |
| pe_wdata | input | 32 | Protocol-engine write data |
| pe_gnt | output | 1 | Grant (ready), equal to pe_req |
| pe_rdata | output | 32 | Protocol-engine read data |

## Verification
A CPU write takes effect at the rising edge after it is driven. A valid request therefore raises busy at that edge, and busy stays high for one cycle per selected field plus every cycle the set loses arbitration. The bench drives inputs on falling edges and samples on falling edges. It counts busy cycles from the first falling edge after the request edge, and it reads buffer contents only after busy has dropped. Protocol-engine grant and read data are checked in the same cycle as the request. For overlapping transfers, the busy pattern is checked on the 2nd, 3rd and 5th falling edges after the engine releases the RAM.

// File: rtl/msgif_pkg.sv
package msgif_pkg;
  localparam int NFLD    = 5;
  localparam int FIELD_W = 32;
  localparam int REG_W   = 3;
  localparam logic [REG_W-1:0] REG_CMD = 3'd5;
  localparam logic [REG_W-1:0] REG_REQ = 3'd6;
  localparam int DIR_BIT = 7;

  typedef logic [FIELD_W-1:0] word_t;
  typedef logic [NFLD-1:0]    fsel_t;
endpackage

// File: rtl/msgif_ram.sv
module msgif_ram
  import msgif_pkg::*;
#(
  parameter int DEPTH  = 40,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  word_t             wdata,
  output word_t             rdata
);
  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && int'(addr) < DEPTH) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = (int'(addr) < DEPTH) ? mem[addr] : '0;
endmodule

// File: rtl/msgif_arb.sv
module msgif_arb #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N:0] taken;
  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pri
    assign gnt[i]     = req[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req[i];
  end
endmodule

// File: rtl/msgif_set.sv
module msgif_set
  import msgif_pkg::*;
#(
  parameter int NUM_OBJ = 8,
  parameter int OBJ_W   = 4,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_reg,
  input  word_t             wr_data,
  input  logic [REG_W-1:0]  rd_reg,
  output word_t             rd_data,
  output logic              busy,
  output logic              req,
  output logic              req_we,
  output logic [ADDR_W-1:0] req_addr,
  output word_t             req_wdata,
  input  logic              gnt,
  input  word_t             ram_rdata
);
  word_t            buf_q [NFLD];
  fsel_t            cmsk_q;
  logic             cdir_q;
  logic [OBJ_W-1:0] obj_q;
  fsel_t            pend_q;
  logic [REG_W-1:0] cur;
  logic             wr_ok;
  logic             obj_ok;

  assign busy   = |pend_q;
  assign wr_ok  = wr_en && !busy;
  assign obj_ok = (wr_data[OBJ_W-1:0] != '0) && (int'(wr_data[OBJ_W-1:0]) <= NUM_OBJ);

  // lowest pending field goes first
  always_comb begin
    cur = '0;
    for (int i = NFLD - 1; i >= 0; i--) begin
      if (pend_q[i]) cur = REG_W'(i);
    end
  end

  always_comb begin
    int unsigned lin;
    lin       = (int'(obj_q) - 1) * NFLD + int'(cur);
    req       = busy;
    req_we    = cdir_q;
    req_addr  = ADDR_W'(lin);
    req_wdata = buf_q[cur];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NFLD; i++) buf_q[i] <= '0;
      cmsk_q <= '0;
      cdir_q <= 1'b0;
      obj_q  <= '0;
      pend_q <= '0;
    end else begin
      if (wr_ok) begin
        if (int'(wr_reg) < NFLD) begin
          buf_q[wr_reg] <= wr_data;
        end else if (wr_reg == REG_CMD) begin
          cmsk_q <= wr_data[NFLD-1:0];
          cdir_q <= wr_data[DIR_BIT];
        end else if (wr_reg == REG_REQ) begin
          obj_q <= wr_data[OBJ_W-1:0];
          if (obj_ok) pend_q <= cmsk_q;
        end
      end
      if (gnt) begin
        pend_q[cur] <= 1'b0;
        if (!cdir_q) buf_q[cur] <= ram_rdata;
      end
    end
  end

  always_comb begin
    if (int'(rd_reg) < NFLD)      rd_data = buf_q[rd_reg];
    else if (rd_reg == REG_CMD)   rd_data = FIELD_W'({cdir_q, 2'b00, cmsk_q});
    else if (rd_reg == REG_REQ)   rd_data = FIELD_W'(obj_q);
    else                          rd_data = '0;
  end

  // R5
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> ($stable(cmsk_q) && $stable(cdir_q) && $stable(obj_q)));
  // R6
  bad_obj_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wr_reg == REG_REQ && !obj_ok) |=> !busy);
  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && wr_reg == REG_REQ));
  // R4
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(gnt));
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !gnt) |=> $stable(pend_q));
endmodule

// File: rtl/msgif_hub.sv
module msgif_hub
  import msgif_pkg::*;
#(
  parameter int NUM_OBJ = 8,
  parameter int OBJ_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic              cpu_sel,
  input  logic [REG_W-1:0]  cpu_reg,
  input  logic [31:0]       cpu_wdata,
  input  logic              cpu_rsel,
  input  logic [REG_W-1:0]  cpu_rreg,
  output logic [31:0]       cpu_rdata,
  output logic [1:0]        busy,
  input  logic              pe_req,
  input  logic              pe_we,
  input  logic [OBJ_W-1:0]  pe_obj,
  input  logic [REG_W-1:0]  pe_fld,
  input  logic [31:0]       pe_wdata,
  output logic              pe_gnt,
  output logic [31:0]       pe_rdata
);
  localparam int NSET   = 2;
  localparam int NREQ   = NSET + 1;
  localparam int DEPTH  = NUM_OBJ * NFLD;
  localparam int ADDR_W = $clog2(DEPTH);

  logic [NREQ-1:0]   rq, gt;
  logic              rwe  [NREQ];
  logic [ADDR_W-1:0] radr [NREQ];
  word_t             rwd  [NREQ];
  word_t             set_rd [NSET];
  word_t             ram_rdata;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  word_t             ram_wdata;

  always_comb begin
    int unsigned lin;
    lin     = (int'(pe_obj) - 1) * NFLD + int'(pe_fld);
    rq[0]   = pe_req;
    rwe[0]  = pe_we;
    radr[0] = ADDR_W'(lin);
    rwd[0]  = pe_wdata;
  end

  for (genvar s = 0; s < NSET; s++) begin : g_set
    msgif_set #(.NUM_OBJ(NUM_OBJ), .OBJ_W(OBJ_W), .ADDR_W(ADDR_W)) u_set (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cpu_we && (cpu_sel == 1'(s))),
      .wr_reg    (cpu_reg),
      .wr_data   (cpu_wdata),
      .rd_reg    (cpu_rreg),
      .rd_data   (set_rd[s]),
      .busy      (busy[s]),
      .req       (rq[s+1]),
      .req_we    (rwe[s+1]),
      .req_addr  (radr[s+1]),
      .req_wdata (rwd[s+1]),
      .gnt       (gt[s+1]),
      .ram_rdata (ram_rdata)
    );
  end

  msgif_arb #(.N(NREQ)) u_arb (.req(rq), .gnt(gt));

  always_comb begin
    ram_we    = 1'b0;
    ram_addr  = '0;
    ram_wdata = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (gt[i]) begin
        ram_we    = rwe[i];
        ram_addr  = radr[i];
        ram_wdata = rwd[i];
      end
    end
  end

  msgif_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  assign pe_gnt    = gt[0];
  assign pe_rdata  = gt[0] ? ram_rdata : '0;
  assign cpu_rdata = set_rd[cpu_rsel];

  // R7
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gt));
  // R8
  pe_first_chk: assert property (@(posedge clk) disable iff (!rst_n) pe_req |-> pe_gnt);
  // R7
  set_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy[0] && !pe_req) |-> !gt[2]);
endmodule

// File: tb/tb_msgif_hub.sv
module tb_msgif_hub;
  localparam int NUM_OBJ = 8;
  localparam int OBJ_W   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_we = 1'b0, cpu_sel = 1'b0, cpu_rsel = 1'b0;
  logic [2:0] cpu_reg = '0, cpu_rreg = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic [1:0] busy;
  logic pe_req = 1'b0, pe_we = 1'b0, pe_gnt;
  logic [OBJ_W-1:0] pe_obj = '0;
  logic [2:0] pe_fld = '0;
  logic [31:0] pe_wdata = '0, pe_rdata;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [31:0] m_ram [0:NUM_OBJ][0:4];
  logic [31:0] m_buf [0:1][0:4];

  always #4 clk = ~clk;

  msgif_hub #(.NUM_OBJ(NUM_OBJ), .OBJ_W(OBJ_W)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_sel(cpu_sel), .cpu_reg(cpu_reg),
    .cpu_wdata(cpu_wdata), .cpu_rsel(cpu_rsel), .cpu_rreg(cpu_rreg), .cpu_rdata(cpu_rdata),
    .busy(busy), .pe_req(pe_req), .pe_we(pe_we), .pe_obj(pe_obj), .pe_fld(pe_fld),
    .pe_wdata(pe_wdata), .pe_gnt(pe_gnt), .pe_rdata(pe_rdata));

  // {set, obj[3:0], dir, fields[4:0], seed[7:0]}
  localparam logic [18:0] VEC [0:10] = '{
    {1'b0, 4'd1, 1'b1, 5'b11111, 8'h10},
    {1'b1, 4'd1, 1'b0, 5'b11111, 8'h00},
    {1'b1, 4'd2, 1'b1, 5'b00101, 8'h20},
    {1'b0, 4'd2, 1'b0, 5'b00100, 8'h00},
    {1'b0, 4'd8, 1'b1, 5'b11000, 8'h30},
    {1'b1, 4'd8, 1'b0, 5'b11011, 8'h00},
    {1'b0, 4'd0, 1'b1, 5'b11111, 8'h40},
    {1'b1, 4'd9, 1'b1, 5'b11111, 8'h50},
    {1'b1, 4'd1, 1'b0, 5'b11111, 8'h00},
    {1'b0, 4'd5, 1'b1, 5'b00000, 8'h60},
    {1'b1, 4'd5, 1'b0, 5'b11111, 8'h00}
  };

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input int s, input int r, input logic [31:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_sel = s[0]; cpu_reg = 3'(r); cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(input int s, input int r, output logic [31:0] d);
    cpu_rsel = s[0]; cpu_rreg = 3'(r);
    #1 d = cpu_rdata;
  endtask

  task automatic wait_idle(input int s, output int n);
    n = 0;
    while (busy[s] && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] val(input int seed, input int s, input int f);
    return {8'(seed), 8'(f), 8'(s), 8'h5A};
  endfunction

  task automatic check_buf(input int s, input string rq);
    logic [31:0] d;
    for (int f = 0; f < 5; f++) begin
      rd(s, f, d);
      chk(rq, $sformatf("set%0d field%0d", s, f), d, m_buf[s][f]);
    end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    for (int o = 0; o <= NUM_OBJ; o++) for (int f = 0; f < 5; f++) m_ram[o][f] = '0;
    for (int s = 0; s < 2; s++) for (int f = 0; f < 5; f++) m_buf[s][f] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "busy", 32'(busy), 32'd0);
    chk("R10", "pe_gnt", 32'(pe_gnt), 32'd0);
    check_buf(0, "R10");
    check_buf(1, "R10");
    rd(1, 5, d); chk("R10", "cmd", d, 32'd0);

    // table of transfers
    for (int v = 0; v < 11; v++) begin
      int s, ob, dir, seed, nexp;
      logic [4:0] fm;
      bit ok;
      s = int'(VEC[v][18]); ob = int'(VEC[v][17:14]); dir = int'(VEC[v][13]);
      fm = VEC[v][12:8]; seed = int'(VEC[v][7:0]);
      ok = (ob >= 1) && (ob <= NUM_OBJ);
      if (dir == 1) begin
        for (int f = 0; f < 5; f++) begin
          wr(s, f, val(seed, s, f));
          m_buf[s][f] = val(seed, s, f);
        end
      end
      wr(s, 5, {24'd0, dir[0], 2'b00, fm});
      rd(s, 5, d); chk("R1", "cmd readback", d, {24'd0, dir[0], 2'b00, fm});
      wr(s, 6, 32'(ob));
      wait_idle(s, n);
      nexp = (ok && fm != 0) ? $countones(fm) : 0;
      chk(ok && fm != 0 ? "R4" : "R6", $sformatf("vec%0d busy cycles", v), 32'(n), 32'(nexp));
      rd(s, 6, d); chk("R1", "obj readback", d, 32'(ob));
      if (ok) begin
        for (int f = 0; f < 5; f++) begin
          if (fm[f]) begin
            if (dir == 1) m_ram[ob][f] = m_buf[s][f];
            else          m_buf[s][f] = m_ram[ob][f];
          end
        end
      end
      check_buf(s, !ok ? "R6" : (dir == 1 ? "R2" : "R3"));
    end

    // R5 and R7: set held off by engine; writes while busy ignored
    wr(0, 0, 32'h1111_0000);
    m_buf[0][0] = 32'h1111_0000;
    wr(0, 5, 32'h81);
    @(negedge clk); pe_req = 1'b1; pe_we = 1'b0; pe_obj = 4'd7; pe_fld = 3'd0;
    wr(0, 6, 32'd3);
    repeat (3) @(negedge clk);
    chk("R7", "set0 stalled busy", 32'(busy[0]), 32'd1);
    wr(0, 0, 32'h2222_0000);
    wr(0, 5, 32'h9F);
    rd(0, 0, d); chk("R5", "field0 write while busy", d, 32'h1111_0000);
    rd(0, 5, d); chk("R5", "cmd write while busy", d, 32'h81);
    pe_req = 1'b0;
    wait_idle(0, n);
    chk("R7", "stalled set finishes one field", 32'(n), 32'd1);
    m_ram[3][0] = 32'h1111_0000;
    wr(1, 5, 32'h01);
    wr(1, 6, 32'd3);
    wait_idle(1, n);
    m_buf[1][0] = m_ram[3][0];
    check_buf(1, "R5");

    // R7 priority: both sets queued behind the engine
    wr(0, 5, 32'h07);
    wr(1, 5, 32'h03);
    @(negedge clk); pe_req = 1'b1;
    wr(0, 6, 32'd3);
    wr(1, 6, 32'd3);
    pe_req = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R7", "both busy after 2", 32'(busy), 32'd3);
    @(negedge clk);
    chk("R7", "set0 done first", 32'(busy), 32'd2);
    @(negedge clk); @(negedge clk);
    chk("R7", "set1 done after", 32'(busy), 32'd0);
    for (int f = 0; f < 3; f++) m_buf[0][f] = m_ram[3][f];
    for (int f = 0; f < 2; f++) m_buf[1][f] = m_ram[3][f];
    check_buf(0, "R7");
    check_buf(1, "R7");

    // R9 overlapping write on set0 and read on set1 of the same object
    for (int f = 0; f < 5; f++) begin
      wr(0, f, val(8'h77, 0, f));
      m_buf[0][f] = val(8'h77, 0, f);
    end
    wr(0, 5, 32'h9F);
    wr(1, 5, 32'h1F);
    @(negedge clk); pe_req = 1'b1;
    wr(0, 6, 32'd6);
    wr(1, 6, 32'd6);
    pe_req = 1'b0;
    wait_idle(1, n);
    for (int f = 0; f < 5; f++) begin
      m_ram[6][f] = m_buf[0][f];
      m_buf[1][f] = m_buf[0][f];
    end
    check_buf(1, "R9");
    check_buf(0, "R9");

    // R8 engine port: write, read back, then fetch through set1
    @(negedge clk);
    pe_req = 1'b1; pe_we = 1'b1; pe_obj = 4'd4; pe_fld = 3'd3; pe_wdata = 32'hDEAD_BEEF;
    #1 chk("R8", "pe_gnt same cycle", 32'(pe_gnt), 32'd1);
    @(negedge clk);
    pe_we = 1'b0;
    #1 chk("R8", "pe read after write", pe_rdata, 32'hDEAD_BEEF);
    pe_obj = 4'd1; pe_fld = 3'd4;
    #1 chk("R8", "pe read set-written field", pe_rdata, m_ram[1][4]);
    @(negedge clk);
    pe_req = 1'b0;
    m_ram[4][3] = 32'hDEAD_BEEF;
    wr(1, 5, 32'h08);
    wr(1, 6, 32'd4);
    wait_idle(1, n);
    m_buf[1][3] = m_ram[4][3];
    check_buf(1, "R8");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule